// File: doc/BRIEF.md
# Predicated Vector Signed-Sum Reducer

This block collapses one wide vector operand into a single 64-bit signed scalar. The caller supplies the vector, a mask holding one bit per byte of the vector, and a 2-bit element-size code. The vector is cut into equal signed elements of 8, 16 or 32 bits. Each element whose mask bit is set is sign-extended to 64 bits and added to the total. The low 64 bits of that total are returned, and the result replaces the destination value as a whole.

Operands enter on a valid/ready stream and results leave on another. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle (`!out_valid || out_ready`). The entire pipeline freezes while `out_valid` is high and `out_ready` is low. An operand is taken on a rising edge where `in_valid && in_ready`. A result stays on the output, unchanged, until a rising edge where `out_valid && out_ready`.

Inside, the reduction is a balanced adder tree. Its leaves are registered, and the tree is registered again after every two adder levels and after the last level. This gives a fixed latency with no gaps between results.

Top module: `vec_sadd_reduce`

## Requirements
- R1: Size code 0, 1 and 2 select 8-, 16- and 32-bit elements. Element e takes bits [e*w +: w] of `in_vec`, so element 0 sits at the least-significant bits.
- R2: Size code 3 is illegal. Its result beat carries `out_err` = 1 and `out_sum` = 0. Legal codes give `out_err` = 0.
- R3: Each active element is read as two's complement and sign-extended to 64 bits before it is summed. For example, an all-ones byte adds -1.
- R4: An element is active when the mask bit of its lowest byte (mask bit e*w/8) is 1. Mask bits of the element's other bytes have no effect on the result.
- R5: Inactive elements add zero. An all-zero mask gives `out_sum` = 0 exactly.
- R6: `out_sum` is the full signed sum reduced modulo 2^64. A negative total appears in 64-bit two's complement, with no saturation and no flag.
- R7: With `out_ready` held high, a result appears exactly LAT rising edges after its accepting edge. LAT = 1 + ceil(log2(VEC_W/8)/2), which is 3 for a 64-bit vector and 4 for a 256-bit vector. Results leave in the order the operands were accepted.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_sum` and `out_err` hold steady and `in_ready` is 0. Once `out_ready` rises, no result is lost or duplicated.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operand is offered |
| in_ready | output | 1 | The block can take an operand this cycle |
| in_vec | input | VEC_W | Vector operand, element 0 at the LSBs |
| in_pred | input | VEC_W/8 | Per-byte activity mask |
| in_size | input | 2 | Element-size code (0: 8, 1: 16, 2: 32, 3: illegal) |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result |
| out_sum | output | 64 | Wrapped signed sum |
| out_err | output | 1 | The result came from an illegal size code |

## Verification
The assertions assume that the size code and mask stay known whenever `in_valid` is high. They also assume that the consumer does not change its mind about a held result, so a result it stalls stays stalled until `out_ready` rises. The bench drives every input on the falling edge, keeps all fields defined even while idle, and only lowers `out_ready` inside the dedicated back-pressure sequence. The mask sweep covers every mask value for every legal size on a 64-bit configuration. Expected sums are computed arithmetically from the mask bit of each element's lowest byte.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } esize_e;

  localparam int unsigned SUM_W = 64;

  // leaf register plus one register per two tree levels (last level always registered)
  function automatic int unsigned tree_latency(input int unsigned leaves);
    int unsigned lv;
    lv = $clog2(leaves);
    return 1 + lv / 2 + lv % 2;
  endfunction

endpackage

// File: rtl/sadd_leaf_terms.sv
module sadd_leaf_terms
  import sadd_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  parameter int unsigned ACC_W = 64,
  localparam int unsigned NBYTE = VEC_W / 8
) (
  input  logic [VEC_W-1:0] vec_i,
  input  logic [NBYTE-1:0] pred_i,
  input  logic [1:0]       size_i,
  output logic [ACC_W-1:0] term_o [NBYTE]
);

  // one term slot per byte; a slot only carries an element that starts on it
  for (genvar i = 0; i < NBYTE; i++) begin : g_slot
    logic [ACC_W-1:0] ext8, ext16, ext32;

    assign ext8 = {{(ACC_W-8){vec_i[i*8+7]}}, vec_i[i*8 +: 8]};

    if ((i % 2) == 0 && (i + 1) < NBYTE) begin : g_h
      assign ext16 = {{(ACC_W-16){vec_i[i*8+15]}}, vec_i[i*8 +: 16]};
    end else begin : g_hn
      assign ext16 = '0;
    end

    if ((i % 4) == 0 && (i + 3) < NBYTE) begin : g_w
      assign ext32 = {{(ACC_W-32){vec_i[i*8+31]}}, vec_i[i*8 +: 32]};
    end else begin : g_wn
      assign ext32 = '0;
    end

    always_comb begin
      term_o[i] = '0;
      if (pred_i[i]) begin
        unique case (esize_e'(size_i))
          SZ_BYTE: term_o[i] = ext8;
          SZ_HALF: term_o[i] = ext16;
          SZ_WORD: term_o[i] = ext32;
          default: term_o[i] = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/sadd_add_tree.sv
module sadd_add_tree #(
  parameter int unsigned LEAVES = 32,
  parameter int unsigned W      = 64,
  localparam int unsigned LVLS  = $clog2(LEAVES)
) (
  input  logic         clk,
  input  logic         adv_i,
  input  logic [W-1:0] leaf_i [LEAVES],
  output logic [W-1:0] sum_o
);

  logic [W-1:0] node [LVLS+1][LEAVES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    always_ff @(posedge clk) begin
      if (adv_i) node[0][j] <= leaf_i[j];
    end
  end

  for (genvar k = 1; k <= LVLS; k++) begin : g_lvl
    localparam int unsigned CNT = LEAVES >> k;
    localparam bit          REG = ((k % 2) == 0) || (k == LVLS);
    for (genvar j = 0; j < LEAVES; j++) begin : g_node
      if (j < CNT) begin : g_add
        if (REG) begin : g_q
          always_ff @(posedge clk) begin
            if (adv_i) node[k][j] <= node[k-1][2*j] + node[k-1][2*j+1];
          end
        end else begin : g_c
          assign node[k][j] = node[k-1][2*j] + node[k-1][2*j+1];
        end
      end else begin : g_unused
        assign node[k][j] = '0;
      end
    end
  end

  assign sum_o = node[LVLS][0];

endmodule

// File: rtl/vec_sadd_reduce.sv
module vec_sadd_reduce
  import sadd_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  localparam int unsigned NBYTE = VEC_W / 8,
  localparam int unsigned LAT   = tree_latency(NBYTE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_vec,
  input  logic [NBYTE-1:0] in_pred,
  input  logic [1:0]       in_size,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [63:0]      out_sum,
  output logic             out_err
);

  logic [SUM_W-1:0] terms [NBYTE];
  logic [LAT-1:0]   vld_q;
  logic [LAT-1:0]   err_q;
  logic             adv;
  logic             any_term;

  // whole pipeline stalls together when the held result is not taken
  assign adv      = !vld_q[LAT-1] || out_ready;
  assign in_ready = adv;

  sadd_leaf_terms #(.VEC_W(VEC_W), .ACC_W(SUM_W)) u_terms (
    .vec_i  (in_vec),
    .pred_i (in_pred),
    .size_i (in_size),
    .term_o (terms)
  );

  sadd_add_tree #(.LEAVES(NBYTE), .W(SUM_W)) u_tree (
    .clk    (clk),
    .adv_i  (adv),
    .leaf_i (terms),
    .sum_o  (out_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      err_q <= '0;
    end else if (adv) begin
      vld_q <= {vld_q[LAT-2:0], in_valid};
      err_q <= {err_q[LAT-2:0], in_valid && (in_size == SZ_BAD)};
    end
  end

  assign out_valid = vld_q[LAT-1];
  assign out_err   = err_q[LAT-1];

  always_comb begin
    any_term = 1'b0;
    for (int i = 0; i < int'(NBYTE); i++) any_term = any_term | (|terms[i]);
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_err))) // R8
    else $error("held result changed");

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready) // R8
    else $error("input accepted during stall");

  AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_sum == '0)) // R2
    else $error("illegal size produced nonzero sum");

  AST_BAD_NO_TERMS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == SZ_BAD) |-> !any_term) // R2
    else $error("illegal size fed the tree");

  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pred == '0) |-> !any_term) // R5
    else $error("empty mask fed the tree");

endmodule

// File: tb/test_vec_sadd_reduce.sv
module test_vec_sadd_reduce;
  localparam int CLK_PERIOD = 10;
  localparam int VW  = 64;
  localparam int NB  = VW / 8;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_vec = '0;
  logic [NB-1:0] in_pred = '0;
  logic [1:0]    in_size = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [63:0]   out_sum;
  logic          out_err;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_sadd_reduce #(.VEC_W(VW)) i_vec_sadd_reduce (
    .clk, .rst_n, .in_valid, .in_ready, .in_vec, .in_pred, .in_size,
    .out_valid, .out_ready, .out_sum, .out_err
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint model(input logic [VW-1:0] v, input logic [NB-1:0] p, input int s);
    longint acc = 0;
    int w, n;
    if (s == 3) return 0;
    w = 8 << s;
    n = VW / w;
    for (int e = 0; e < n; e++) begin
      longint raw, sb;
      if (p[e * (w / 8)]) begin
        raw = longint'((v >> (e * w)) & ((64'd1 << w) - 1));
        sb  = longint'(64'd1 << (w - 1));
        acc += (raw ^ sb) - sb;
      end
    end
    return acc;
  endfunction

  // send one operand with out_ready high, check latency, sum and flag
  task automatic run_one(input logic [VW-1:0] v, input logic [NB-1:0] p, input int s, input string tag);
    int cnt = 0;
    longint exp = model(v, p, s);
    @(negedge clk);
    in_valid = 1'b1; in_vec = v; in_pred = p; in_size = 2'(s);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 1;
    while (!out_valid && cnt < 20) begin @(negedge clk); cnt++; end
    chk(cnt == LAT, "R7 latency", cnt, LAT);
    chk(out_sum == 64'(exp), tag, out_sum, exp);
    chk(out_err == (s == 3), "R2 flag", out_err, (s == 3));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R9 in_ready", in_ready, 1);

    // R1 placement and width
    run_one(64'h01, 8'h01, 0, "R1 byte0");
    run_one(64'h0100, 8'h01, 0, "R1 byte1 excluded");
    run_one(64'h0100, 8'h01, 1, "R1 half0");
    run_one(64'h0001_0000_0000, 8'h10, 2, "R1 word1");
    // R3 sign extension
    run_one({8{8'hFF}}, 8'hFF, 0, "R3 minus ones");
    run_one({8{8'h80}}, 8'hFF, 0, "R3 min bytes");
    run_one({4{16'h8000}}, 8'h55, 1, "R3 min halves");
    // R6 negative total in two's complement
    run_one(64'h8000_0000_8000_0000, 8'h11, 2, "R6 neg wrap");
    // R4 upper-byte mask bits ignored
    run_one({8{8'h7F}}, 8'hEE, 2, "R4 upper bits only");
    run_one({8{8'h7F}}, 8'hAA, 1, "R4 odd bits only");
    // R5 empty mask
    run_one({8{8'h9C}}, 8'h00, 0, "R5 empty");
    // R2 illegal
    run_one({8{8'h11}}, 8'hFF, 3, "R2 illegal sum");

    // near-exhaustive: every mask, every legal size, two vectors each
    for (int s = 0; s < 3; s++) begin
      for (int p = 0; p < 256; p++) begin
        run_one({$urandom(), $urandom()}, 8'(p), s, "R5 mask sweep");
        run_one({8{8'(p)}} ^ 64'hA5C3_0F96_7E18_3CB4, 8'(p), s, "R3 mask sweep");
      end
    end

    // R8 back-pressure: two results, held then drained in order
    begin
      logic [VW-1:0] va = 64'h0102_0304_0506_0708;
      logic [VW-1:0] vb = {8{8'hFE}};
      longint ea = model(va, 8'hFF, 0);
      longint eb = model(vb, 8'hFF, 0);
      longint got;
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1; in_vec = va; in_pred = 8'hFF; in_size = 2'd0;
      @(negedge clk);
      in_vec = vb;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (LAT + 2) @(negedge clk);
      chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
      chk(in_ready == 1'b0, "R8 in_ready low", in_ready, 0);
      got = out_sum;
      chk(got == ea, "R8 first result", got, ea);
      repeat (3) @(negedge clk);
      chk(out_sum == 64'(got), "R8 stable", out_sum, got);
      out_ready = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b1 && out_sum == 64'(eb), "R8 second result", out_sum, eb);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 no duplicate", out_valid, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule